// File: doc/BRIEF.md
# Dual-Scan Panel Timing Generator

This block turns the horizontal and vertical sync of an incoming pixel stream into the control timing that a passive-matrix panel expects. Each sync input can be inverted before use. Internal timing starts on the rising edge of each corrected sync. The block then produces a line pulse and a first-line marker. The delay, width and output polarity of each are programmable in pixel clocks.

A dual-scan panel refreshes its upper and lower halves at the same time. For such a panel the block issues one first-line marker at the start of the frame and a second one when the line count reaches half the programmed total. Line pulses are issued either on every line or only on active lines. The continuous choice is ignored when the panel is an active-matrix (TFT) type. A bypass mode sends the raw sync and data-enable inputs straight to the outputs. In normal mode, data enable is delayed by one clock.

Top module: `panel_timing_gen`

## Requirements
- R1: Each sync input is XORed with its own inversion bit before use. Only a 0-to-1 transition of the corrected signal counts as an edge.
- R2: A horizontal edge sampled at clock edge n makes the line pulse active for the `cfg_lp_width` clocks that follow edge n+`cfg_lp_delay`. The output is inverted when `cfg_lp_inv`=1. The marker output follows the same rule with its own delay, width and inversion.
- R3: The first horizontal edge after a vertical edge is line 0, and it always triggers a first-line marker.
- R4: With `cfg_dual`=1, the line whose index equals `cfg_total_lines`>>1 also triggers a marker. With `cfg_dual`=0, no line other than line 0 triggers one.
- R5: Lines with index below `cfg_total_lines` are active. With `cfg_lp_cont`=0, lines at or beyond the total give no line pulse. With `cfg_lp_cont`=1 and `cfg_tft`=0, every line gives a line pulse.
- R6: With `cfg_tft`=1, `cfg_lp_cont` has no effect, and lines at or beyond the total give no line pulse.
- R7: Every vertical edge restarts line numbering at 0, even in the middle of a frame.
- R8: With `cfg_bypass`=1, `lp_out`, `flm_out` and `de_out` equal `hsync_in`, `vsync_in` and `de_in` in the same cycle, without inversion.
- R9: With `cfg_bypass`=0, `de_out` equals the `de_in` value sampled at the previous clock edge.
- R10: A width of 0 suppresses the pulse entirely.
- R11: While reset is held, `lp_out` equals `cfg_lp_inv`, `flm_out` equals `cfg_flm_inv`, and `de_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_in | input | 1 | Incoming horizontal sync |
| vsync_in | input | 1 | Incoming vertical sync |
| de_in | input | 1 | Incoming data enable |
| cfg_hs_inv | input | 1 | Invert horizontal sync before use |
| cfg_vs_inv | input | 1 | Invert vertical sync before use |
| cfg_lp_inv | input | 1 | Line pulse output active low |
| cfg_flm_inv | input | 1 | Marker output active low |
| cfg_lp_delay | input | PW_W | Line pulse delay in clocks |
| cfg_lp_width | input | PW_W | Line pulse width in clocks |
| cfg_flm_delay | input | PW_W | Marker delay in clocks |
| cfg_flm_width | input | PW_W | Marker width in clocks |
| cfg_total_lines | input | CNT_W | Lines per frame |
| cfg_dual | input | 1 | Dual-scan panel: add the mid-frame marker |
| cfg_lp_cont | input | 1 | Line pulses on every line |
| cfg_tft | input | 1 | Active-matrix panel |
| cfg_bypass | input | 1 | Forward raw inputs to outputs |
| lp_out | output | 1 | Line pulse |
| flm_out | output | 1 | First-line marker |
| de_out | output | 1 | Data enable |

## Verification
The bench builds the block with `CNT_W`=6 and `PW_W`=4. The 4-bit fields let random delays run from zero to seven and widths from zero to seven. Every pulse therefore fits inside a 16-clock line, and each clock of each line can be compared with its expected value. Totals of 4 to 12 lines keep frames short, so each frame can include lines past the total. Many random frames with mixed inversion bits, single and dual scan, and TFT and continuous settings fit well within the run budget.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef struct packed {
    logic lp;
    logic flm;
    logic de;
  } ptg_out_t;

  localparam int unsigned NUM_SYNC = 2;
  localparam int unsigned IDX_H = 0;
  localparam int unsigned IDX_V = 1;
endpackage

// File: rtl/ptg_edge_det.sv
module ptg_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic inv,
  output logic rise
);
  logic level;
  logic prev_q;
  logic prev_d;

  assign level  = raw ^ inv;
  assign prev_d = level;
  assign rise   = level & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  AST_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> prev_q); // R1
endmodule

// File: rtl/ptg_line_ctrl.sv
module ptg_line_ctrl #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_rise,
  input  logic             vs_rise,
  input  logic [CNT_W-1:0] cfg_total_lines,
  input  logic             cfg_dual,
  input  logic             cfg_lp_cont,
  input  logic             cfg_tft,
  output logic             lp_trig,
  output logic             flm_trig
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] line_idx;
  logic [CNT_W-1:0] half_lines;
  logic             active;
  logic             cont_ok;

  always_comb begin
    line_idx   = vs_rise ? '0 : cnt_q;
    half_lines = cfg_total_lines >> 1;
    active     = line_idx < cfg_total_lines;
    cont_ok    = cfg_lp_cont & ~cfg_tft;
    lp_trig    = hs_rise & (active | cont_ok);
    flm_trig   = hs_rise & ((line_idx == '0) | (cfg_dual & (line_idx == half_lines)));
    cnt_d      = cnt_q;
    if (vs_rise)                       cnt_d = hs_rise ? CNT_W'(1) : '0;
    else if (hs_rise && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (cnt_q <= CNT_W'(1))); // R7
  AST_SINGLE_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    (flm_trig && !cfg_dual) |-> (line_idx == '0)); // R4
  AST_TFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_trig && cfg_tft) |-> (line_idx < cfg_total_lines)); // R6
endmodule

// File: rtl/ptg_pulse_gen.sv
module ptg_pulse_gen #(
  parameter int unsigned PW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic [PW_W-1:0] delay,
  input  logic [PW_W-1:0] width,
  output logic            pulse
);
  logic [PW_W-1:0] dly_q, dly_d;
  logic [PW_W-1:0] wid_q, wid_d;

  always_comb begin
    dly_d = dly_q;
    wid_d = wid_q;
    if (trig) begin
      if (delay == '0) begin
        dly_d = '0;
        wid_d = width;
      end else begin
        dly_d = delay;
        wid_d = '0;
      end
    end else if (dly_q != '0) begin
      dly_d = dly_q - PW_W'(1);
      if (dly_q == PW_W'(1)) wid_d = width;
    end else if (wid_q != '0) begin
      wid_d = wid_q - PW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      wid_q <= '0;
    end else begin
      dly_q <= dly_d;
      wid_q <= wid_d;
    end
  end

  assign pulse = (wid_q != '0);

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> ($past(trig) || $past(dly_q == PW_W'(1)))); // R2
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned PW_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             de_in,
  input  logic             cfg_hs_inv,
  input  logic             cfg_vs_inv,
  input  logic             cfg_lp_inv,
  input  logic             cfg_flm_inv,
  input  logic [PW_W-1:0]  cfg_lp_delay,
  input  logic [PW_W-1:0]  cfg_lp_width,
  input  logic [PW_W-1:0]  cfg_flm_delay,
  input  logic [PW_W-1:0]  cfg_flm_width,
  input  logic [CNT_W-1:0] cfg_total_lines,
  input  logic             cfg_dual,
  input  logic             cfg_lp_cont,
  input  logic             cfg_tft,
  input  logic             cfg_bypass,
  output logic             lp_out,
  output logic             flm_out,
  output logic             de_out
);
  import ptg_pkg::*;

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [NUM_SYNC-1:0] sync_raw, sync_inv, sync_rise;
  assign sync_raw = {vsync_in, hsync_in};
  assign sync_inv = {cfg_vs_inv, cfg_hs_inv};

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_edge
    ptg_edge_det u_edge (
      .clk  (clk),
      .rst_n(rst_sync),
      .raw  (sync_raw[g]),
      .inv  (sync_inv[g]),
      .rise (sync_rise[g])
    );
  end

  logic lp_trig, flm_trig;
  ptg_line_ctrl #(.CNT_W(CNT_W)) u_line (
    .clk            (clk),
    .rst_n          (rst_sync),
    .hs_rise        (sync_rise[IDX_H]),
    .vs_rise        (sync_rise[IDX_V]),
    .cfg_total_lines(cfg_total_lines),
    .cfg_dual       (cfg_dual),
    .cfg_lp_cont    (cfg_lp_cont),
    .cfg_tft        (cfg_tft),
    .lp_trig        (lp_trig),
    .flm_trig       (flm_trig)
  );

  logic [1:0]           pg_trig, pg_pulse;
  logic [1:0][PW_W-1:0] pg_delay, pg_width;
  assign pg_trig  = {flm_trig, lp_trig};
  assign pg_delay = {cfg_flm_delay, cfg_lp_delay};
  assign pg_width = {cfg_flm_width, cfg_lp_width};

  for (genvar p = 0; p < 2; p++) begin : g_pulse
    ptg_pulse_gen #(.PW_W(PW_W)) u_pulse (
      .clk  (clk),
      .rst_n(rst_sync),
      .trig (pg_trig[p]),
      .delay(pg_delay[p]),
      .width(pg_width[p]),
      .pulse(pg_pulse[p])
    );
  end

  logic de_q, de_d;
  assign de_d = de_in;
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) de_q <= 1'b0;
    else           de_q <= de_d;
  end

  ptg_out_t gen_out, sel_out;
  always_comb begin
    gen_out.lp  = pg_pulse[0] ^ cfg_lp_inv;
    gen_out.flm = pg_pulse[1] ^ cfg_flm_inv;
    gen_out.de  = de_q;
    sel_out     = cfg_bypass ? '{lp: hsync_in, flm: vsync_in, de: de_in} : gen_out;
  end

  assign lp_out  = sel_out.lp;
  assign flm_out = sel_out.flm;
  assign de_out  = sel_out.de;

  AST_DE_DELAY: assert property (@(posedge clk) disable iff (!rst_sync)
    (!cfg_bypass && $past(rst_sync)) |-> (de_out == $past(de_in))); // R9
endmodule

// File: tb/test_panel_timing_gen.sv
module test_panel_timing_gen;
  localparam int CNT_W = 6;
  localparam int PW_W  = 4;
  localparam int PER   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 0, vsync_in = 0, de_in = 0;
  logic cfg_hs_inv = 0, cfg_vs_inv = 0, cfg_lp_inv = 0, cfg_flm_inv = 0;
  logic [PW_W-1:0] cfg_lp_delay = 0, cfg_lp_width = 0, cfg_flm_delay = 0, cfg_flm_width = 0;
  logic [CNT_W-1:0] cfg_total_lines = 0;
  logic cfg_dual = 0, cfg_lp_cont = 0, cfg_tft = 0, cfg_bypass = 0;
  logic lp_out, flm_out, de_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic de_last = 0;

  always #10 clk = ~clk;

  panel_timing_gen #(.CNT_W(CNT_W), .PW_W(PW_W)) i_panel_timing_gen (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in), .de_in(de_in),
    .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv), .cfg_lp_inv(cfg_lp_inv),
    .cfg_flm_inv(cfg_flm_inv), .cfg_lp_delay(cfg_lp_delay), .cfg_lp_width(cfg_lp_width),
    .cfg_flm_delay(cfg_flm_delay), .cfg_flm_width(cfg_flm_width),
    .cfg_total_lines(cfg_total_lines), .cfg_dual(cfg_dual), .cfg_lp_cont(cfg_lp_cont),
    .cfg_tft(cfg_tft), .cfg_bypass(cfg_bypass),
    .lp_out(lp_out), .flm_out(flm_out), .de_out(de_out));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  function automatic logic exp_pulse(input logic fire, input int k, input int d, input int w);
    return fire && (k >= d) && (k < d + w);
  endfunction

  function automatic logic exp_lp_fire(input int line, input int tot, input logic cont, input logic tft);
    return (line < tot) || (cont && !tft);
  endfunction

  function automatic logic exp_flm_fire(input int line, input int tot, input logic dual);
    return (line == 0) || (dual && line == (tot >> 1));
  endfunction

  function automatic string lp_tag(input int line, input int tot, input int w, input logic tft);
    if (w == 0) return "R10 lp";
    if (line >= tot) return tft ? "R6 lp" : "R5 lp";
    return "R2 R1 lp";
  endfunction

  function automatic string flm_tag(input int line, input int w, input int frame);
    if (w == 0) return "R10 flm";
    if (line == 0) return (frame > 0) ? "R7 R3 flm" : "R3 flm";
    return "R4 flm";
  endfunction

  task automatic run_frame(input int frame, input logic hi, input logic vi, input logic lpi,
                           input logic fmi, input int ld, input int lw, input int fd, input int fw,
                           input int tot, input logic dual, input logic cont, input logic tft);
    logic lfire, ffire;
    @(negedge clk);
    cfg_hs_inv = hi; cfg_vs_inv = vi; cfg_lp_inv = lpi; cfg_flm_inv = fmi;
    cfg_lp_delay = PW_W'(ld); cfg_lp_width = PW_W'(lw);
    cfg_flm_delay = PW_W'(fd); cfg_flm_width = PW_W'(fw);
    cfg_total_lines = CNT_W'(tot); cfg_dual = dual; cfg_lp_cont = cont; cfg_tft = tft;
    cfg_bypass = 1'b0;
    hsync_in = hi; vsync_in = vi;
    repeat (3) @(negedge clk);
    vsync_in = ~vi;
    repeat (3) @(negedge clk);
    vsync_in = vi;
    repeat (2) @(negedge clk);
    for (int line = 0; line < tot + 2; line++) begin
      hsync_in = ~hi;
      lfire = exp_lp_fire(line, tot, cont, tft);
      ffire = exp_flm_fire(line, tot, dual);
      for (int k = 0; k < PER; k++) begin
        @(negedge clk);
        chk(lp_tag(line, tot, lw, tft), lp_out, exp_pulse(lfire, k, ld, lw) ^ lpi);
        chk(flm_tag(line, fw, frame), flm_out, exp_pulse(ffire, k, fd, fw) ^ fmi);
        chk("R9 de", de_out, de_last);
        de_last = 1'($urandom);
        de_in = de_last;
        if (k == 1) hsync_in = hi;
      end
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R11 lp", lp_out, 1'b0);
    chk("R11 flm", flm_out, 1'b0);
    chk("R11 de", de_out, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corners
    run_frame(0, 0, 0, 0, 0, 2, 3, 0, 2, 8, 1, 0, 0);  // dual, mid marker at 4
    run_frame(1, 1, 1, 1, 1, 0, 1, 3, 4, 7, 0, 0, 0);  // single, inverted
    run_frame(2, 0, 1, 0, 0, 1, 2, 1, 1, 5, 1, 1, 1);  // R6 tft ignores continuous
    run_frame(3, 1, 0, 0, 1, 7, 7, 0, 3, 4, 0, 1, 0);  // R5 continuous
    run_frame(4, 0, 0, 1, 0, 3, 0, 2, 0, 6, 1, 0, 0);  // R10 zero widths

    for (int f = 5; f < 17; f++) begin
      run_frame(f, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
                4 + int'($urandom % 9), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // R8 bypass forwards raw inputs
    @(negedge clk);
    cfg_bypass = 1'b1; cfg_hs_inv = 1; cfg_vs_inv = 1; cfg_lp_inv = 1; cfg_flm_inv = 1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      hsync_in = 1'($urandom); vsync_in = 1'($urandom); de_in = 1'($urandom);
      #1;
      chk("R8 lp", lp_out, hsync_in);
      chk("R8 flm", flm_out, vsync_in);
      chk("R8 de", de_out, de_in);
    end
    de_last = de_in;
    repeat (PER + 4) @(negedge clk);

    run_frame(17, 0, 1, 0, 1, 2, 2, 1, 5, 9, 1, 0, 0);
    finish_run();
  end
endmodule